// File: doc/BRIEF.md
# Event Identifier Matching Controller

This block holds a queue of 36-bit event identifiers and works through them one at a time. For the identifier being worked on, it sends request strobes to a set of readout channels at a fixed interval. Each request carries a rotating 4-bit request number. It then watches the channels' match reports. A report counts only when it comes from an enabled channel and names the current identifier. The block keeps one matched flag per channel. It retires the identifier once every enabled channel has matched.

A host controls the block through a small set of write strobes. It can park the state machine, skip an identifier that never matches, change the request interval and enable or disable channels. On the read side it sees the current and newest identifiers, the queue fill level, the retry count, the request number and the per-channel flags. The link encoding on both sides is outside the block: the request is a single strobe, and the reports arrive as a valid bit plus an identifier for each channel.

Top module: `evid_match_ctrl`

## Requirements
- R1: After reset the block is halted (`halted_o`=1), every channel is enabled, the request interval is 2047 cycles, and all of the following are zero: queue count, current and newest identifiers, retry count, request number, matched flags, `busy_o` and `req_o`.
- R2: Identifiers presented on `id_i` with `id_valid_i` enter a first-in first-out queue holding QDEPTH entries. A push while the queue is full is dropped. `newest_id_o` takes every presented identifier, including dropped ones. `q_count_o` counts queued entries and does not include the current identifier.
- R3: When no identifier is current and the queue is not empty, the queue head becomes the current identifier on the next edge, and `busy_o` rises.
- R4: While halted, `req_o` stays low, the retry count does not change, and matches on every enabled channel do not retire the current identifier.
- R5: A `force_i` pulse retires the current identifier without a match only while halted. While running, `force_i` is ignored.
- R6: While running with a current identifier, `req_o` is high in the first running cycle. After that it is high once every max(interval,1) cycles. During a request, `req_evid_o` shows the current identifier and `req_id_o` shows the request number.
- R7: The retry count rises by one for each request cycle, stops at 0xFFFF, and is zero whenever a new identifier becomes current.
- R8: A report on channel c (valid bit c, identifier in bits c*36 and up of `rpt_id_i`) sets matched flag c on the next edge. This happens only if channel c is enabled and the reported identifier equals the current one. Any other report is ignored.
- R9: While running, once every enabled channel's matched flag is set, the identifier retires on the next edge. Disabled channels are not waited for. With no channel enabled, retirement happens at once.
- R10: Each retirement, whether by match or by force, clears all matched flags and adds one to the request number modulo 16. It then loads the queue head, or returns to idle with `busy_o` low if the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_valid_i | input | 1 | Push strobe for a new identifier |
| id_i | input | 36 | Identifier to push |
| halt_wr_i | input | 1 | Write strobe for the halt bit |
| halt_i | input | 1 | Halt bit value |
| force_i | input | 1 | Skip the current identifier (honoured only while halted) |
| ivl_wr_i | input | 1 | Write strobe for the request interval |
| ivl_i | input | 16 | Request interval in cycles |
| ch_en_wr_i | input | 1 | Write strobe for the channel enables |
| ch_en_i | input | NUM_CH | Channel enable values |
| rpt_valid_i | input | NUM_CH | Per-channel match report valid |
| rpt_id_i | input | NUM_CH*36 | Per-channel reported identifier |
| req_o | output | 1 | Request strobe to the channels |
| req_id_o | output | 4 | Current request number |
| req_evid_o | output | 36 | Identifier carried by the request |
| busy_o | output | 1 | An identifier is current |
| cur_id_o | output | 36 | Identifier being matched |
| newest_id_o | output | 36 | Most recently presented identifier |
| q_count_o | output | QCNT_W | Queued identifiers, excluding the current one |
| retry_o | output | 16 | Requests sent for the current identifier |
| ch_en_o | output | NUM_CH | Channel enables |
| matched_o | output | NUM_CH | Per-channel matched flags |
| halted_o | output | 1 | Halt bit |

## Verification
The bench fills the queue beyond its depth and then drains it with forces. A design that overwrote the oldest entry, or counted a dropped push, would show the wrong current identifier and the wrong count. It sends reports with a wrong identifier, from a disabled channel, and while halted. A design that set flags from these reports, or retired on them, would change `matched_o` or `req_id_o`. It includes a mask with no channel enabled, to catch an all-matched reduction that ignores disabled channels. It measures request spacing at the default interval and at a short interval, which exposes an off-by-one in the timer reload and a retry count that is not cleared on a new identifier.

// File: rtl/evid_match_pkg.sv
package evid_match_pkg;
  localparam int unsigned EVID_W  = 36;
  localparam int unsigned RID_W   = 4;
  localparam int unsigned IVL_W   = 16;
  localparam int unsigned RETRY_W = 16;
  localparam logic [IVL_W-1:0] IVL_RST = 16'h07FF;

  typedef logic [EVID_W-1:0] evid_t;
  typedef enum logic {ST_IDLE = 1'b0, ST_MATCH = 1'b1} st_e;
endpackage

// File: rtl/evid_fifo.sv
module evid_fifo
  import evid_match_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  evid_t            data_i,
  input  logic             pop_i,
  output evid_t            data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o
);
  evid_t            mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && (cnt_q < CNT_W'(DEPTH));
  assign pop_ok  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  a_r2_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(DEPTH) && !pop_i) |=> cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/evid_req_timer.sv
module evid_req_timer
  import evid_match_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [IVL_W-1:0] ivl_i,
  output logic             fire_o
);
  logic [IVL_W-1:0] cnt_q;

  assign fire_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (restart_i)    cnt_q <= '0;
    else if (fire_o)       cnt_q <= (ivl_i == '0) ? '0 : ivl_i - 1'b1;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  a_r6_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !restart_i && ivl_i > 16'd1) |=> !fire_o);
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !restart_i) |=> $stable(cnt_q));
endmodule

// File: rtl/evid_ch_slot.sv
module evid_ch_slot
  import evid_match_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_wr_i,
  input  logic  en_d_i,
  input  logic  active_i,
  input  logic  clr_i,
  input  logic  rpt_valid_i,
  input  evid_t rpt_id_i,
  input  evid_t cur_id_i,
  output logic  en_o,
  output logic  matched_o
);
  logic en_q, matched_q, hit;

  assign hit       = active_i && en_q && rpt_valid_i && (rpt_id_i == cur_id_i);
  assign en_o      = en_q;
  assign matched_o = matched_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b1;
      matched_q <= 1'b0;
    end else begin
      if (en_wr_i) en_q <= en_d_i;
      if (clr_i)    matched_q <= 1'b0;
      else if (hit) matched_q <= 1'b1;
    end
  end

  a_r8_set_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(matched_q) |-> $past(rpt_valid_i) && $past(en_q));
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !matched_q);
endmodule

// File: rtl/evid_match_ctrl.sv
module evid_match_ctrl
  import evid_match_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned QDEPTH = 8,
  localparam int unsigned QCNT_W = $clog2(QDEPTH + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     id_valid_i,
  input  logic [EVID_W-1:0]        id_i,
  input  logic                     halt_wr_i,
  input  logic                     halt_i,
  input  logic                     force_i,
  input  logic                     ivl_wr_i,
  input  logic [IVL_W-1:0]         ivl_i,
  input  logic                     ch_en_wr_i,
  input  logic [NUM_CH-1:0]        ch_en_i,
  input  logic [NUM_CH-1:0]        rpt_valid_i,
  input  logic [NUM_CH*EVID_W-1:0] rpt_id_i,
  output logic                     req_o,
  output logic [RID_W-1:0]         req_id_o,
  output logic [EVID_W-1:0]        req_evid_o,
  output logic                     busy_o,
  output logic [EVID_W-1:0]        cur_id_o,
  output logic [EVID_W-1:0]        newest_id_o,
  output logic [QCNT_W-1:0]        q_count_o,
  output logic [RETRY_W-1:0]       retry_o,
  output logic [NUM_CH-1:0]        ch_en_o,
  output logic [NUM_CH-1:0]        matched_o,
  output logic                     halted_o
);
  st_e                st_q;
  evid_t              cur_q, newest_q, head;
  logic               halt_q, active, all_done, adv, load, empty, fire;
  logic [IVL_W-1:0]   ivl_q;
  logic [RID_W-1:0]   rid_q;
  logic [RETRY_W-1:0] retry_q;
  logic [NUM_CH-1:0]  en_w, matched_w;

  assign active   = (st_q == ST_MATCH);
  assign all_done = &(matched_w | ~en_w);
  assign adv      = active && (halt_q ? force_i : all_done);
  assign load     = (!active || adv) && !empty;

  evid_fifo #(.DEPTH(QDEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (id_valid_i),
    .data_i (id_i),
    .pop_i  (load),
    .data_o (head),
    .count_o(q_count_o),
    .empty_o(empty)
  );

  evid_req_timer u_timer (
    .clk_i, .rst_ni,
    .run_i    (active && !halt_q),
    .restart_i(load || adv),
    .ivl_i    (ivl_q),
    .fire_o   (fire)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    evid_ch_slot u_slot (
      .clk_i, .rst_ni,
      .en_wr_i    (ch_en_wr_i),
      .en_d_i     (ch_en_i[c]),
      .active_i   (active),
      .clr_i      (adv),
      .rpt_valid_i(rpt_valid_i[c]),
      .rpt_id_i   (rpt_id_i[c*EVID_W +: EVID_W]),
      .cur_id_i   (cur_q),
      .en_o       (en_w[c]),
      .matched_o  (matched_w[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cur_q    <= '0;
      newest_q <= '0;
      halt_q   <= 1'b1;
      ivl_q    <= IVL_RST;
      rid_q    <= '0;
      retry_q  <= '0;
    end else begin
      if (id_valid_i) newest_q <= id_i;
      if (halt_wr_i)  halt_q   <= halt_i;
      if (ivl_wr_i)   ivl_q    <= ivl_i;
      if (adv)        rid_q    <= rid_q + 1'b1;
      if (load) begin
        st_q  <= ST_MATCH;
        cur_q <= head;
      end else if (adv) begin
        st_q <= ST_IDLE;
      end
      if (load || adv)                  retry_q <= '0;
      else if (fire && retry_q != '1)   retry_q <= retry_q + 1'b1;
    end
  end

  assign req_o       = fire;
  assign req_id_o    = rid_q;
  assign req_evid_o  = cur_q;
  assign busy_o      = active;
  assign cur_id_o    = cur_q;
  assign newest_id_o = newest_q;
  assign retry_o     = retry_q;
  assign ch_en_o     = en_w;
  assign matched_o   = matched_w;
  assign halted_o    = halt_q;

  a_r4_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && halt_q && !force_i) |=> $stable(cur_q) && busy_o);
  a_r4_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q |-> !req_o);
  a_r10_rid_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> req_id_o == $past(req_id_o) + 1'b1);
  a_r7_retry_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> retry_o == '0);
  a_r10_flags_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> matched_o == '0);
endmodule

// File: tb/sim_evid_match_ctrl.sv
module sim_evid_match_ctrl;
  localparam int NCH = 4;
  localparam int QD  = 8;
  localparam int IW  = 36;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            id_valid_i = 1'b0;
  logic [IW-1:0]   id_i = '0;
  logic            halt_wr_i = 1'b0, halt_i = 1'b0, force_i = 1'b0;
  logic            ivl_wr_i = 1'b0;
  logic [15:0]     ivl_i = '0;
  logic            ch_en_wr_i = 1'b0;
  logic [NCH-1:0]  ch_en_i = '0;
  logic [NCH-1:0]  rpt_valid_i = '0;
  logic [NCH*IW-1:0] rpt_id_i = '0;
  logic            req_o, busy_o, halted_o;
  logic [3:0]      req_id_o;
  logic [IW-1:0]   req_evid_o, cur_id_o, newest_id_o;
  logic [3:0]      q_count_o;
  logic [15:0]     retry_o;
  logic [NCH-1:0]  ch_en_o, matched_o;

  int total = 0, bad = 0;
  bit done = 0;

  evid_match_ctrl #(.NUM_CH(NCH), .QDEPTH(QD)) u0 (.*);

  always #2 clk_i = ~clk_i;

  // {en[3:0], report mask[3:0], expect retire}
  localparam logic [8:0] VEC [7] = '{
    9'b1111_1111_1, 9'b1111_0111_0, 9'b0101_0101_1, 9'b0101_1010_0,
    9'b0000_0000_1, 9'b1000_1001_1, 9'b0110_0100_0
  };

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [IW-1:0] v);
    id_valid_i = 1'b1; id_i = v; tick(); id_valid_i = 1'b0;
  endtask

  task automatic set_halt(input logic h);
    halt_wr_i = 1'b1; halt_i = h; tick(); halt_wr_i = 1'b0;
  endtask

  task automatic set_en(input logic [NCH-1:0] e);
    ch_en_wr_i = 1'b1; ch_en_i = e; tick(); ch_en_wr_i = 1'b0;
  endtask

  task automatic do_force();
    force_i = 1'b1; tick(); force_i = 1'b0;
  endtask

  task automatic report(input logic [NCH-1:0] m, input logic [IW-1:0] v);
    rpt_valid_i = m; rpt_id_i = {NCH{v}}; tick(); rpt_valid_i = '0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [3:0] exp_rid;
    int n;
    #5 rst_ni = 1'b1;
    tick();
    // R1 reset state
    chk(halted_o, 1, "R1 halt");
    chk(ch_en_o, 4'hF, "R1 enables");
    chk(q_count_o, 0, "R1 count");
    chk({busy_o, req_o}, 0, "R1 busy/req");
    chk(cur_id_o | newest_id_o, 0, "R1 ids");
    chk({retry_o, req_id_o, matched_o}, 0, "R1 retry/rid/matched");

    // R3 load, R2 count excludes current
    push(36'hA_0000_0001);
    push(36'hB_0000_0002);
    chk(cur_id_o, 36'hA_0000_0001, "R3 load head");
    chk(busy_o, 1, "R3 busy");
    chk(q_count_o, 1, "R2 count");
    chk(newest_id_o, 36'hB_0000_0002, "R2 newest");
    // R4 halted: no requests
    n = 0;
    for (int i = 0; i < 5; i++) begin if (req_o) n++; tick(); end
    chk(n, 0, "R4 no req while halted");
    chk(retry_o, 0, "R4 retry frozen");

    // R5 force while halted
    do_force();
    chk(cur_id_o, 36'hB_0000_0002, "R5 force advances");
    chk(req_id_o, 1, "R10 rid step");
    chk(q_count_o, 0, "R2 count after pop");

    // R1/R6 default interval 2047
    set_halt(1'b0);
    chk(req_o, 1, "R6 first req");
    chk(req_evid_o, 36'hB_0000_0002, "R6 req evid");
    n = 0;
    do begin tick(); n++; end while (!req_o && n < 3000);
    chk(n, 2047, "R1 default interval");
    chk(retry_o, 1, "R7 retry count");

    // R6/R7 interval 3 on fresh identifier
    set_halt(1'b1);
    ivl_wr_i = 1'b1; ivl_i = 16'd3; id_valid_i = 1'b1; id_i = 36'hC_0000_0003;
    tick(); ivl_wr_i = 1'b0; id_valid_i = 1'b0;
    tick();
    do_force();
    chk(cur_id_o, 36'hC_0000_0003, "R10 next loaded");
    chk(retry_o, 0, "R7 retry cleared");
    chk(req_id_o, 2, "R10 rid");
    set_halt(1'b0);
    n = 0;
    for (int i = 0; i < 9; i++) begin if (req_o) n++; tick(); end
    chk(n, 3, "R6 interval 3 count");
    chk(retry_o, 3, "R7 retry after 3");

    // R8/R9/R5 matching
    push(36'hD_0000_0004);
    report(4'b0001, 36'hC_0000_0013);
    chk(matched_o, 0, "R8 wrong id ignored");
    report(4'b0110, 36'hC_0000_0003);
    chk(matched_o, 4'b0110, "R8 flags set");
    set_en(4'b0111);
    report(4'b1000, 36'hC_0000_0003);
    chk(matched_o, 4'b0110, "R8 disabled ignored");
    do_force();
    chk(cur_id_o, 36'hC_0000_0003, "R5 force ignored running");
    report(4'b0001, 36'hC_0000_0003);
    chk(matched_o, 4'b0111, "R8 last flag");
    tick();
    chk(cur_id_o, 36'hD_0000_0004, "R9 retire on match");
    chk(matched_o, 0, "R10 flags cleared");
    chk(req_id_o, 3, "R10 rid");
    chk(retry_o, 0, "R7 retry new id");
    set_en(4'hF);
    set_halt(1'b1);
    do_force();
    chk(busy_o, 0, "R10 idle on empty");
    chk(req_id_o, 4, "R10 rid");

    // vector walk: R4 halted matches hold, R9 retire rules
    exp_rid = 4'd4;
    for (int k = 0; k < 7; k++) begin
      logic [IW-1:0] v;
      v = 36'h5_0000_0000 + 36'(k);
      set_en(VEC[k][8:5]);
      push(v);
      tick();
      chk(cur_id_o, v, "R3 vec load");
      report(VEC[k][4:1], v);
      tick();
      chk(busy_o, 1, "R4 halted no retire");
      set_halt(1'b0);
      tick();
      chk(busy_o, !VEC[k][0], "R9 vector retire");
      if (VEC[k][0]) exp_rid++;
      set_halt(1'b1);
      if (busy_o) begin do_force(); exp_rid++; end
      chk(req_id_o, exp_rid, "R10 vector rid");
    end

    // R2 queue overflow and order
    set_en(4'hF);
    for (int k = 0; k < 10; k++) push(36'hE_0000_0000 + 36'(k));
    chk(q_count_o, QD, "R2 full count");
    chk(cur_id_o, 36'hE_0000_0000, "R2 first");
    chk(newest_id_o, 36'hE_0000_0009, "R2 newest dropped");
    do_force();
    chk(cur_id_o, 36'hE_0000_0001, "R2 order");
    chk(q_count_o, QD - 1, "R2 count dec");
    for (int k = 0; k < 7; k++) do_force();
    chk(cur_id_o, 36'hE_0000_0008, "R2 overflow dropped");
    chk(q_count_o, 0, "R2 drained");
    do_force();
    chk(busy_o, 0, "R10 idle");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule